// File: doc/BRIEF.md
# SIMT Divergence Execution Mask Unit

This unit tracks which lanes of a lockstep wavefront may write back results while the wavefront walks if/else control flow on one shared program counter. The sequencer raises a branch strobe together with a per-lane condition vector. It then raises an else strobe when it switches to the other path, and a converge strobe at the point where the paths join again. The unit keeps the current active-lane mask and turns it into per-lane commit enables, so that masked lanes still execute but their results are dropped.

A stack stores the enclosing mask and the taken set of every open branch, which lets branches nest. The taken set is always computed inside the enclosing active set. The else path is the enclosing set minus the taken set. Reconvergence restores the saved enclosing mask exactly, instead of rebuilding it from an AND of conditions. A path whose mask comes out all zeros raises an empty-path flag, so that the sequencer can skip that path. Stack overflow and underflow are reported as one-cycle error pulses.

Top module: `simt_mask_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mask is reset to all ones, the stack is emptied, and `empty_path`, `ovf_err` and `unf_err` are cleared.
- R2: A branch strobe (`br`) with a stack that is not full sets the mask, at the next edge, to `cond & mask`, where bit i is lane i. It also pushes the old mask (the parent) and the new mask (the taken set).
- R3: An else strobe (`els`) with a non-empty stack sets the mask, at the next edge, to the parent on top of the stack AND NOT the taken set on top of the stack. The stack is left unchanged.
- R4: A converge strobe (`conv`) with a non-empty stack sets the mask, at the next edge, to the parent on top of the stack, and pops that entry.
- R5: `commit_en` equals `mask & {LANES{wb_valid}}` in the same cycle. A write-back in a cycle that carries a strobe is therefore gated by the mask from before that strobe.
- R6: `empty_path` goes high on the edge after a valid branch or else whose new mask is zero. It goes low on the edge after any other valid strobe, and otherwise holds its value.
- R7: A branch with DEPTH entries on the stack raises `ovf_err` for exactly the next cycle. The mask, the stack and `empty_path` are left unchanged.
- R8: An else or converge with an empty stack raises `unf_err` for exactly the next cycle. The mask and `empty_path` are left unchanged.
- R9: Branches nested DEPTH deep reconverge in last-in, first-out order. Each converge restores the mask that was in force before the matching branch.
- R10: In a cycle with no strobe, the mask holds its value. Strobes are mutually exclusive within a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond | input | LANES | Per-lane branch condition, bit i is lane i |
| br | input | 1 | Branch strobe |
| els | input | 1 | Else strobe |
| conv | input | 1 | Converge strobe |
| wb_valid | input | 1 | An instruction is writing back this cycle |
| mask | output | LANES | Current active-lane mask |
| commit_en | output | LANES | Per-lane write-back enable |
| empty_path | output | 1 | The last computed path mask was all zeros |
| ovf_err | output | 1 | Branch was refused because the stack was full |
| unf_err | output | 1 | Else or converge was refused because the stack was empty |

## Verification
Commit gating and a mask update can fall in the same cycle: a write-back that coincides with a branch, else or converge must use the mask from before the strobe. The bench provokes this by asserting `wb_valid` at random alongside every kind of strobe, including strobes that overflow or underflow. It judges `commit_en` shortly after the inputs settle, against the model's mask from before the strobe. The bench also drives an overflowing branch whose condition vector is zero. This checks that the error pulse appears while `empty_path` and the mask stay untouched.

// File: rtl/simt_mask_pkg.sv
// Package: shared strobe encoding for the divergence mask unit.
// Assumes at most one strobe per cycle. If several are raised, the order is branch, then else, then converge.
package simt_mask_pkg;
    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_BR   = 2'd1,
        STB_ELS  = 2'd2,
        STB_CONV = 2'd3
    } strobe_e;

    // Turn the three strobe inputs into a single kind.
    function automatic strobe_e strobe_decode(input logic b, input logic e, input logic c);
        if (b)      return STB_BR;
        else if (e) return STB_ELS;
        else if (c) return STB_CONV;
        else        return STB_NONE;
    endfunction
endpackage

// File: rtl/simt_mask_stack.sv
// Module: LIFO of (parent mask, taken mask) pairs, one pair per open branch.
// Assumes the caller never pushes when full or pops when empty. Such requests are ignored.
// The top-of-stack outputs read zero when the stack is empty.
module simt_mask_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_parent,
    input  logic [W-1:0] push_taken,
    output logic [W-1:0] top_parent,
    output logic [W-1:0] top_taken,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  par_mem [DEPTH];
    logic [W-1:0]  tak_mem [DEPTH];
    logic [PW-1:0] cnt;
    logic [AW-1:0] top_idx;

    assign full    = (cnt == PW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = AW'(cnt - PW'(1));

    // Occupancy counter: up on a push, down on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (push && !full)  cnt <= cnt + PW'(1);
        else if (pop && !empty)  cnt <= cnt - PW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Entry g captures the pushed pair when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                par_mem[g] <= '0;
                tak_mem[g] <= '0;
            end else if (push && !full && cnt == PW'(g)) begin
                par_mem[g] <= push_parent;
                tak_mem[g] <= push_taken;
            end
        end
    end

    // Top-of-stack read port.
    always_comb begin
        top_parent = empty ? '0 : par_mem[top_idx];
        top_taken  = empty ? '0 : tak_mem[top_idx];
    end
endmodule

// File: rtl/simt_mask_next.sv
// Module: combinational next-mask and stack-control logic.
// Assumes the top-of-stack values come from simt_mask_stack and that the stack status is current.
module simt_mask_next
    import simt_mask_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_mask,
    input  logic [W-1:0] cond,
    input  logic         br,
    input  logic         els,
    input  logic         conv,
    input  logic [W-1:0] top_parent,
    input  logic [W-1:0] top_taken,
    input  logic         full,
    input  logic         empty,
    output logic [W-1:0] next_mask,
    output logic         do_push,
    output logic         do_pop,
    output logic         ovf,
    output logic         unf,
    output logic         upd_empty,
    output logic         new_empty
);
    strobe_e kind;
    logic [W-1:0] taken;

    assign kind  = strobe_decode(br, els, conv);
    assign taken = cond & cur_mask;

    // Choose the new mask and stack action for this cycle's strobe.
    always_comb begin
        next_mask = cur_mask;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        ovf       = 1'b0;
        unf       = 1'b0;
        upd_empty = 1'b0;
        new_empty = 1'b0;
        unique case (kind)
            STB_BR: begin
                if (full) ovf = 1'b1;
                else begin
                    next_mask = taken;
                    do_push   = 1'b1;
                    upd_empty = 1'b1;
                    new_empty = (taken == '0);
                end
            end
            STB_ELS: begin
                if (empty) unf = 1'b1;
                else begin
                    next_mask = top_parent & ~top_taken;
                    upd_empty = 1'b1;
                    new_empty = ((top_parent & ~top_taken) == '0);
                end
            end
            STB_CONV: begin
                if (empty) unf = 1'b1;
                else begin
                    next_mask = top_parent;
                    do_pop    = 1'b1;
                    upd_empty = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/simt_mask_unit.sv
// Module: top of the divergence execution mask unit.
// It holds the active-lane mask, gates write-back per lane, and reports empty paths and stack errors.
// Assumes strobes are mutually exclusive. The reset is synchronous and active low.
module simt_mask_unit #(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cond,
    input  logic             br,
    input  logic             els,
    input  logic             conv,
    input  logic             wb_valid,
    output logic [LANES-1:0] mask,
    output logic [LANES-1:0] commit_en,
    output logic             empty_path,
    output logic             ovf_err,
    output logic             unf_err
);
    logic [LANES-1:0] next_mask, top_parent, top_taken;
    logic do_push, do_pop, ovf, unf, upd_empty, new_empty, full, empty;

    simt_mask_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
        .push_parent(mask), .push_taken(next_mask),
        .top_parent(top_parent), .top_taken(top_taken),
        .full(full), .empty(empty)
    );

    simt_mask_next #(.W(LANES)) u_next (
        .cur_mask(mask), .cond(cond), .br(br), .els(els), .conv(conv),
        .top_parent(top_parent), .top_taken(top_taken), .full(full), .empty(empty),
        .next_mask(next_mask), .do_push(do_push), .do_pop(do_pop),
        .ovf(ovf), .unf(unf), .upd_empty(upd_empty), .new_empty(new_empty)
    );

    // Mask, empty-path and error-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= '1;
            empty_path <= 1'b0;
            ovf_err    <= 1'b0;
            unf_err    <= 1'b0;
        end else begin
            mask    <= next_mask;
            ovf_err <= ovf;
            unf_err <= unf;
            if (upd_empty) empty_path <= new_empty;
        end
    end

    // Per-lane write-back gate, taken from the mask in force this cycle.
    assign commit_en = mask & {LANES{wb_valid}};
endmodule

// File: rtl/simt_mask_checker.sv
// Module: property checker for simt_mask_unit, attached through bind.
// Assumes the same clock and active-low reset as the unit it watches.
module simt_mask_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         br,
    input logic         els,
    input logic         conv,
    input logic [W-1:0] mask,
    input logic [W-1:0] commit_en,
    input logic         empty_path,
    input logic         ovf_err,
    input logic         unf_err
);
    AST_RESET_ONES: assert property (@(posedge clk) $rose(rst_n) |-> (mask == '1 && !empty_path && !ovf_err && !unf_err)); // R1
    AST_BR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) br |=> ((mask & ~$past(mask)) == '0)); // R2
    AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n) ((commit_en & ~mask) == '0)); // R5
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) empty_path |-> (mask == '0)); // R6
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_err) |-> $past(br)); // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |-> $stable(mask)); // R7
    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(unf_err) |-> $past(els || conv)); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!br && !els && !conv) |=> $stable(mask)); // R10
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $countones({br, els, conv}) <= 1); // R10
endmodule

bind simt_mask_unit simt_mask_checker #(.W(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .br(br), .els(els), .conv(conv),
    .mask(mask), .commit_en(commit_en), .empty_path(empty_path),
    .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/sim_simt_mask_unit.sv
// Bench: drives nested if/else sequences and compares against a behavioural queue model on every clock.
module sim_simt_mask_unit;
    localparam int LANES = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] cond = '0;
    logic br = 1'b0, els = 1'b0, conv = 1'b0, wb_valid = 1'b0;
    logic [LANES-1:0] mask, commit_en;
    logic empty_path, ovf_err, unf_err;

    int checks = 0;
    int bad = 0;
    bit nest_phase = 1'b0;

    // Model state.
    logic [LANES-1:0] m_mask = '1;
    logic [LANES-1:0] q_par [$];
    logic [LANES-1:0] q_tak [$];
    bit m_empty = 0, m_ovf = 0, m_unf = 0;

    simt_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cond(cond), .br(br), .els(els), .conv(conv),
        .wb_valid(wb_valid), .mask(mask), .commit_en(commit_en),
        .empty_path(empty_path), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock of stimulus. Commit is checked before the edge, state after it.
    task automatic step(input bit b, input bit e, input bit c, input logic [LANES-1:0] cv, input bit wb);
        string mtag;
        logic [LANES-1:0] t;
        br = b; els = e; conv = c; cond = cv; wb_valid = wb;
        #2;
        check("R5 commit_en", commit_en, m_mask & {LANES{wb}});
        @(posedge clk);
        m_ovf = 0; m_unf = 0; mtag = "R10 mask hold";
        if (b) begin
            if (q_par.size() == DEPTH) begin m_ovf = 1; mtag = "R7 mask on overflow"; end
            else begin
                t = cv & m_mask;
                q_par.push_back(m_mask); q_tak.push_back(t);
                m_mask = t; m_empty = (t == '0); mtag = "R2 branch mask";
            end
        end else if (e) begin
            if (q_par.size() == 0) begin m_unf = 1; mtag = "R8 mask on underflow"; end
            else begin
                m_mask = q_par[$] & ~q_tak[$]; m_empty = (m_mask == '0); mtag = "R3 else mask";
            end
        end else if (c) begin
            if (q_par.size() == 0) begin m_unf = 1; mtag = "R8 mask on underflow"; end
            else begin
                m_mask = q_par.pop_back(); void'(q_tak.pop_back()); m_empty = 0;
                mtag = nest_phase ? "R9 nested restore" : "R4 converge mask";
            end
        end
        @(negedge clk);
        check(mtag, mask, m_mask);
        check("R6 empty_path", LANES'(empty_path), LANES'(m_empty));
        check("R7 ovf_err", LANES'(ovf_err), LANES'(m_ovf));
        check("R8 unf_err", LANES'(unf_err), LANES'(m_unf));
    endtask

    initial begin
        #3000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset mask", mask, '1);
        check("R1 reset flags", LANES'({empty_path, ovf_err, unf_err}), '0);
        // R8 right after reset: the stack must be empty.
        step(0, 0, 1, '0, 1);
        step(0, 1, 0, '0, 0);
        // Basic if/else/converge, single lane taken.
        step(1, 0, 0, 16'h0001, 1);
        step(0, 0, 0, '0, 1);
        step(0, 1, 0, '0, 1);
        step(0, 0, 1, '0, 1);
        // Nested: the inner else stays inside the outer taken set.
        step(1, 0, 0, 16'h00FF, 0);
        step(1, 0, 0, 16'h0F0F, 1);
        step(0, 1, 0, '0, 1);
        step(0, 0, 1, '0, 1);
        step(0, 1, 0, '0, 1);
        step(0, 0, 1, '0, 0);
        // R6 empty paths: zero taken set, then a zero else set.
        step(1, 0, 0, 16'h0000, 1);
        step(0, 1, 0, '0, 1);
        step(0, 0, 1, '0, 1);
        step(1, 0, 0, 16'hFFFF, 1);
        step(0, 1, 0, '0, 1);
        step(0, 0, 1, '0, 1);
        // R9 nest DEPTH deep, R7 overflow with a zero condition, then unwind.
        nest_phase = 1;
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, ~(16'h1 << i), i[0]);
        step(1, 0, 0, 16'h0000, 1);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, '0, 1);
        step(0, 0, 1, '0, 1);
        nest_phase = 0;
        // Random phase with concurrent write-back.
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 5);
            step(k == 0 || k == 1, k == 2, k == 3, LANES'($urandom), 1'($urandom));
        end
        // Reset mid-flight.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        q_par.delete(); q_tak.delete(); m_mask = '1; m_empty = 0;
        #1;
        check("R1 mid reset mask", mask, '1);
        step(0, 0, 1, '0, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule